// File: doc/BRIEF.md
# Handshake Parallel Port Controller

This block gives a processor three parallel ports behind a small register interface: two full-width ports (A and B) and a six-pin port C. A command register sets each wide port's direction, the role of port C, the per-port interrupt enables and a two-bit timer command. The timer command is passed straight out to a separate timer, and the timer's interrupt flag comes back in to be reported.

A wide port works either as a plain port or as a strobed port. A plain port is a latched output or a live input. A strobed port uses three port C pins as its handshake lines: an interrupt request, a buffer-full flag and an active-low strobe from the external device. Port C mode 01 gives these lines to port A only, and the other three pins are outputs. Mode 10 gives them to both ports. A status read at the command address collects every flag in one word.

The strobe pins pass through a two-flop synchronizer before edge detection. So a strobe edge at a pin changes the flags on the third rising clock edge after it.

Top module: `handshake_port_ctrl`

## Requirements
- R1: A synchronous reset clears the command register, the output latches, the capture latches and all handshake flags. Every port then reads as input, all output-enable signals are 0, all data outputs are 0 and timerCmd is 0.
- R2: A write with regSel 000 loads the command register. Bit0 is the port A direction and bit1 is the port B direction (1 = output, seen on portAOe/portBOe). Bits 3:2 are the port C mode, bit4 is the port A interrupt enable, bit5 is the port B interrupt enable, and bits 7:6 drive timerCmd.
- R3: A port not in strobed mode is a plain port. A write with regSel 001 (A) or 010 (B) loads its output latch, which drives portAOut/portBOut. A read returns the latch when the port is an output, and the live input pins when it is an input.
- R4: In port C mode 00 all six pins are inputs (portCOe = 0). In mode 11 all six are outputs driven from the latch written with regSel 011. A read with regSel 011 returns, for each pin, the driven value if the pin is an output and the pin input otherwise, in the low six bits.
- R5: In modes 01 and 10, port A is strobed. Pin 0 drives A's interrupt request, pin 1 drives A's buffer-full flag, and pin 2 is A's strobe input. In mode 01, pins 5:3 are outputs from latch bits 5:3.
- R6: In mode 10, port B is also strobed. Pin 3 drives B's interrupt request, pin 4 drives B's buffer-full flag, and pin 5 is B's strobe input.
- R7: A read with regSel 000 returns the status word. Bit0 is A interrupt request, bit1 is A buffer full and bit2 is A interrupt enable. Bit3 is B interrupt request, bit4 is B buffer full and bit5 is B interrupt enable. Bit6 is timerIrq and bit7 is 0.
- R8: For a strobed input port, the falling strobe edge captures the port pins and sets buffer full. The rising edge sets the interrupt request only if that port's enable is 1. Each takes effect on the third rising clock edge after the pin changes.
- R9: A read of a strobed input port returns the captured data, not the live pins, and clears both buffer full and the interrupt request.
- R10: For a strobed output port, a port write sets buffer full and clears the interrupt request. The falling strobe edge clears buffer full, and the rising edge sets the interrupt request if enabled.
- R11: While a port is not in strobed mode, its buffer-full and interrupt flags are held at 0, and strobe pin edges have no effect on them.
- R12: Register selects 100 to 111 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects on port reads) |
| regSel | input | 3 | Register select |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for the selected register |
| portAIn | input | DATA_W | Port A pin inputs |
| portAOut | output | DATA_W | Port A output latch |
| portAOe | output | 1 | Port A drive enable |
| portBIn | input | DATA_W | Port B pin inputs |
| portBOut | output | DATA_W | Port B output latch |
| portBOe | output | 1 | Port B drive enable |
| portCIn | input | 6 | Port C pin inputs (strobes on pins 2 and 5) |
| portCOut | output | 6 | Port C driven values |
| portCOe | output | 6 | Port C per-pin drive enables |
| timerCmd | output | 2 | Timer command from command bits 7:6 |
| timerIrq | input | 1 | Timer interrupt flag, reported in status bit 6 |

## Verification
The bench holds port data steady through the strobe's synchronizer delay and then changes it. A design that returned the live pins instead of the captured byte would read back the new value. Strobe edges are driven with the enable clear, and a missing enable gate would show a set interrupt bit in status. Strobes are also toggled while port C is in a plain mode, where a design that ignores the mode would set flags.

In output mode, the bench checks that a port write clears a pending interrupt. It also checks that dropping out of strobed mode clears the flags; a design that kept stale flags would report them in the status word. Reads and writes to the unused selects are checked as well, since a partial address decode would alias them onto live registers.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int PC_W   = 6;
  localparam int NUM_HS = 2;

  typedef enum logic [2:0] {
    SEL_CMD = 3'd0,
    SEL_PA  = 3'd1,
    SEL_PB  = 3'd2,
    SEL_PC  = 3'd3
  } regSel_e;

  typedef enum logic [1:0] {
    PC_ALL_IN  = 2'b00,
    PC_A_HS    = 2'b01,
    PC_AB_HS   = 2'b10,
    PC_ALL_OUT = 2'b11
  } pcMode_e;

  // command register layout, bit0 first from the right
  typedef struct packed {
    logic [1:0] tmr;
    logic       ieB;
    logic       ieA;
    pcMode_e    pcMode;
    logic       dirB;
    logic       dirA;
  } cmd_t;

  // access strobes from control to datapath
  typedef struct packed {
    logic              wrCmd;
    logic              wrC;
    logic [NUM_HS-1:0] wrPort;
    logic [NUM_HS-1:0] rdPort;
  } acc_t;
endpackage

// File: rtl/hpc_strobe_sync.sv
module hpc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pinIn,
  output logic fallEv,
  output logic riseEv
);
  // sr[STAGES-1] is the synchronized level, sr[STAGES] the previous one
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-1:0], pinIn};
  end

  assign fallEv = sr[STAGES] & ~sr[STAGES-1];
  assign riseEv = ~sr[STAGES] & sr[STAGES-1];
endmodule

// File: rtl/hpc_ctrl.sv
module hpc_ctrl
  import hpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regSel,
  input  pcMode_e           hsMode,
  input  logic [NUM_HS-1:0] dir,
  input  logic [NUM_HS-1:0] ie,
  input  logic [NUM_HS-1:0] pinStb,
  output acc_t              acc,
  output logic [NUM_HS-1:0] hsOn,
  output logic [NUM_HS-1:0] bf,
  output logic [NUM_HS-1:0] intr,
  output logic [NUM_HS-1:0] capEv
);
  always_comb begin
    acc = '0;
    if (regWr) begin
      case (regSel)
        SEL_CMD: acc.wrCmd     = 1'b1;
        SEL_PA:  acc.wrPort[0] = 1'b1;
        SEL_PB:  acc.wrPort[1] = 1'b1;
        SEL_PC:  acc.wrC       = 1'b1;
        default: ;
      endcase
    end
    if (regRd) begin
      case (regSel)
        SEL_PA:  acc.rdPort[0] = 1'b1;
        SEL_PB:  acc.rdPort[1] = 1'b1;
        default: ;
      endcase
    end
  end

  assign hsOn[0] = (hsMode == PC_A_HS) || (hsMode == PC_AB_HS);
  assign hsOn[1] = (hsMode == PC_AB_HS);

  for (genvar p = 0; p < NUM_HS; p++) begin : g_hs
    logic fallEv, riseEv;
    logic bfR, intrR;

    hpc_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .pinIn  (pinStb[p]),
      .fallEv (fallEv),
      .riseEv (riseEv)
    );

    always_ff @(posedge clk) begin
      if (rst || !hsOn[p]) begin
        bfR   <= 1'b0;
        intrR <= 1'b0;
      end else if (!dir[p]) begin
        // strobed input: a port read acknowledges, strobe edges set
        if (acc.rdPort[p]) begin
          bfR   <= 1'b0;
          intrR <= 1'b0;
        end
        if (fallEv)          bfR   <= 1'b1;
        if (riseEv && ie[p]) intrR <= 1'b1;
      end else begin
        // strobed output: strobe acknowledges, a port write refills
        if (fallEv)          bfR   <= 1'b0;
        if (riseEv && ie[p]) intrR <= 1'b1;
        if (acc.wrPort[p]) begin
          bfR   <= 1'b1;
          intrR <= 1'b0;
        end
      end
    end

    assign bf[p]    = bfR;
    assign intr[p]  = intrR;
    assign capEv[p] = hsOn[p] & ~dir[p] & fallEv;
  end
endmodule

// File: rtl/hpc_datapath.sv
module hpc_datapath
  import hpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_t              acc,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] portAIn,
  input  logic [DATA_W-1:0] portBIn,
  input  logic [PC_W-1:0]   portCIn,
  input  logic [NUM_HS-1:0] hsOn,
  input  logic [NUM_HS-1:0] bf,
  input  logic [NUM_HS-1:0] intr,
  input  logic [NUM_HS-1:0] capEv,
  input  logic              timerIrq,
  output cmd_t              cmd,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portBOut,
  output logic [PC_W-1:0]   portCOut,
  output logic [PC_W-1:0]   portCOe
);
  localparam int CMD_W = $bits(cmd_t);

  logic [DATA_W-1:0] outLat [NUM_HS];
  logic [DATA_W-1:0] capLat [NUM_HS];
  logic [DATA_W-1:0] pinIn  [NUM_HS];
  logic [DATA_W-1:0] view   [NUM_HS];
  logic [PC_W-1:0]   latC;
  logic [PC_W-1:0]   pcView;
  logic [NUM_HS-1:0] dir;
  logic [7:0]        statusByte;

  assign pinIn[0] = portAIn;
  assign pinIn[1] = portBIn;
  assign dir      = {cmd.dirB, cmd.dirA};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd  <= '0;
      latC <= '0;
      for (int p = 0; p < NUM_HS; p++) begin
        outLat[p] <= '0;
        capLat[p] <= '0;
      end
    end else begin
      if (acc.wrCmd) cmd  <= cmd_t'(wrData[CMD_W-1:0]);
      if (acc.wrC)   latC <= wrData[PC_W-1:0];
      for (int p = 0; p < NUM_HS; p++) begin
        if (acc.wrPort[p]) outLat[p] <= wrData;
        if (capEv[p])      capLat[p] <= pinIn[p];
      end
    end
  end

  assign portAOut = outLat[0];
  assign portBOut = outLat[1];

  // port C pin roles
  always_comb begin
    portCOe  = '0;
    portCOut = '0;
    case (cmd.pcMode)
      PC_ALL_OUT: begin
        portCOe  = '1;
        portCOut = latC;
      end
      PC_A_HS: begin
        portCOe  = 6'b111011;
        portCOut = {latC[5:3], 1'b0, bf[0], intr[0]};
      end
      PC_AB_HS: begin
        portCOe  = 6'b011011;
        portCOut = {1'b0, bf[1], intr[1], 1'b0, bf[0], intr[0]};
      end
      default: ;
    endcase
  end

  assign pcView = (portCOe & portCOut) | (~portCOe & portCIn);

  for (genvar p = 0; p < NUM_HS; p++) begin : g_view
    assign view[p] = (hsOn[p] && !dir[p]) ? capLat[p] :
                     (dir[p] ? outLat[p] : pinIn[p]);
  end

  assign statusByte = {1'b0, timerIrq, cmd.ieB, bf[1], intr[1],
                       cmd.ieA, bf[0], intr[0]};

  always_comb begin
    case (regSel)
      SEL_CMD: rdData = DATA_W'(statusByte);
      SEL_PA:  rdData = view[0];
      SEL_PB:  rdData = view[1];
      SEL_PC:  rdData = DATA_W'(pcView);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/handshake_port_ctrl.sv
module handshake_port_ctrl
  import hpc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] portAIn,
  output logic [DATA_W-1:0] portAOut,
  output logic              portAOe,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portBOut,
  output logic              portBOe,
  input  logic [5:0]        portCIn,
  output logic [5:0]        portCOut,
  output logic [5:0]        portCOe,
  output logic [1:0]        timerCmd,
  input  logic              timerIrq
);
  cmd_t              cmd;
  acc_t              acc;
  logic [NUM_HS-1:0] hsOn, bf, intr, capEv;

  hpc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .regWr  (regWr),
    .regRd  (regRd),
    .regSel (regSel),
    .hsMode (cmd.pcMode),
    .dir    ({cmd.dirB, cmd.dirA}),
    .ie     ({cmd.ieB, cmd.ieA}),
    .pinStb ({portCIn[5], portCIn[2]}),
    .acc    (acc),
    .hsOn   (hsOn),
    .bf     (bf),
    .intr   (intr),
    .capEv  (capEv)
  );

  hpc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .regSel   (regSel),
    .wrData   (wrData),
    .portAIn  (portAIn),
    .portBIn  (portBIn),
    .portCIn  (portCIn),
    .hsOn     (hsOn),
    .bf       (bf),
    .intr     (intr),
    .capEv    (capEv),
    .timerIrq (timerIrq),
    .cmd      (cmd),
    .rdData   (rdData),
    .portAOut (portAOut),
    .portBOut (portBOut),
    .portCOut (portCOut),
    .portCOe  (portCOe)
  );

  assign portAOe  = cmd.dirA;
  assign portBOe  = cmd.dirB;
  assign timerCmd = cmd.tmr;
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker
  import hpc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              regWr,
  input logic [2:0]        regSel,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] portAOut,
  input logic [DATA_W-1:0] portBOut,
  input logic              portAOe,
  input logic              portBOe,
  input logic [5:0]        portCOut,
  input logic [5:0]        portCOe,
  input logic [1:0]        timerCmd,
  input logic              timerIrq,
  input pcMode_e           pcMode,
  input logic              dirA,
  input logic              ieA,
  input logic              ieB,
  input logic [1:0]        hsOn,
  input logic [1:0]        bf,
  input logic [1:0]        intr
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (portAOe == 1'b0 && portBOe == 1'b0 && portCOe == '0 &&
             portCOut == '0 && portAOut == '0 && portBOut == '0 &&
             timerCmd == 2'b00 && bf == '0 && intr == '0));

  p_pc_inputs_r4: assert property (@(posedge clk) disable iff (rst)
    (pcMode == PC_ALL_IN) |-> (portCOe == '0));

  p_pc_a_lines_r5: assert property (@(posedge clk) disable iff (rst)
    (pcMode == PC_A_HS || pcMode == PC_AB_HS) |->
      (portCOe[2] == 1'b0 && portCOut[0] == intr[0] && portCOut[1] == bf[0]));

  p_pc_b_lines_r6: assert property (@(posedge clk) disable iff (rst)
    (pcMode == PC_AB_HS) |->
      (portCOe[5] == 1'b0 && portCOut[3] == intr[1] && portCOut[4] == bf[1]));

  p_status_top_r7: assert property (@(posedge clk) disable iff (rst)
    (regSel == 3'd0) |-> (rdData[7] == 1'b0 && rdData[6] == timerIrq &&
                          rdData[1] == bf[0] && rdData[4] == bf[1]));

  p_intr_a_needs_ie_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(intr[0]) |-> $past(ieA));

  p_intr_b_needs_ie_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(intr[1]) |-> $past(ieB));

  p_out_write_r10: assert property (@(posedge clk) disable iff (rst)
    (hsOn[0] && dirA && regWr && regSel == 3'd1) |=> (bf[0] && !intr[0]));

  p_idle_flags_a_r11: assert property (@(posedge clk) disable iff (rst)
    (!hsOn[0] && $past(!hsOn[0])) |-> (bf[0] == 1'b0 && intr[0] == 1'b0));

  p_idle_flags_b_r11: assert property (@(posedge clk) disable iff (rst)
    (!hsOn[1] && $past(!hsOn[1])) |-> (bf[1] == 1'b0 && intr[1] == 1'b0));

  p_unused_sel_r12: assert property (@(posedge clk) disable iff (rst)
    regSel[2] |-> (rdData == '0));
endmodule

bind handshake_port_ctrl hpc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .regWr    (regWr),
  .regSel   (regSel),
  .rdData   (rdData),
  .portAOut (portAOut),
  .portBOut (portBOut),
  .portAOe  (portAOe),
  .portBOe  (portBOe),
  .portCOut (portCOut),
  .portCOe  (portCOe),
  .timerCmd (timerCmd),
  .timerIrq (timerIrq),
  .pcMode   (cmd.pcMode),
  .dirA     (cmd.dirA),
  .ieA      (cmd.ieA),
  .ieB      (cmd.ieB),
  .hsOn     (hsOn),
  .bf       (bf),
  .intr     (intr)
);

// File: tb/handshake_port_ctrl_test.sv
`timescale 1ns/1ps
module handshake_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] portAIn = 8'h00;
  logic [7:0] portAOut;
  logic       portAOe;
  logic [7:0] portBIn = 8'h00;
  logic [7:0] portBOut;
  logic       portBOe;
  logic [5:0] portCIn = 6'h3F;
  logic [5:0] portCOut;
  logic [5:0] portCOe;
  logic [1:0] timerCmd;
  logic       timerIrq = 1'b0;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  handshake_port_ctrl uut (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regSel(regSel),
    .wrData(wrData), .rdData(rdData),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe),
    .timerCmd(timerCmd), .timerIrq(timerIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (regRd && !rst) begin
        if (q.size() == 0) chk("scoreboard empty on read", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(it.tag, {24'h0, rdData}, {24'h0, it.exp});
        end
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = s; wrData = d;
    @(negedge clk);
    regWr = 1'b0; regSel = 3'd0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [7:0] e, input string tag);
    @(negedge clk);
    q.push_back('{exp: e, tag: tag});
    regRd = 1'b1; regSel = s;
    @(negedge clk);
    regRd = 1'b0; regSel = 3'd0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // ---- reset (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R1 portAOe after reset", portAOe, 0);
    chk("R1 portBOe after reset", portBOe, 0);
    chk("R1 portCOe after reset", portCOe, 0);
    chk("R1 portAOut after reset", portAOut, 0);
    chk("R1 timerCmd after reset", timerCmd, 0);
    rd(3'd0, 8'h00, "R1 status after reset");

    // ---- command fields (R2, R7)
    wr(3'd0, 8'hC3);
    settle();
    chk("R2 portAOe from bit0", portAOe, 1);
    chk("R2 portBOe from bit1", portBOe, 1);
    chk("R2 timerCmd from bits7:6", timerCmd, 3);
    chk("R2 port C inputs in mode 00", portCOe, 0);
    rd(3'd0, 8'h00, "R7 status with enables off");
    wr(3'd0, 8'h30);
    rd(3'd0, 8'h24, "R7 status enable bits 2 and 5");
    timerIrq = 1'b1;
    rd(3'd0, 8'h64, "R7 status timer bit 6");
    timerIrq = 1'b0;

    // ---- plain ports (R3)
    wr(3'd0, 8'h03);
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'h3C);
    settle();
    chk("R3 portAOut latch", portAOut, 8'hA5);
    chk("R3 portBOut latch", portBOut, 8'h3C);
    rd(3'd1, 8'hA5, "R3 read port A output latch");
    rd(3'd2, 8'h3C, "R3 read port B output latch");
    wr(3'd0, 8'h00);
    portAIn = 8'h5A;
    portBIn = 8'hC3;
    rd(3'd1, 8'h5A, "R3 read port A live input");
    rd(3'd2, 8'hC3, "R3 read port B live input");
    settle();
    chk("R3 port A released", portAOe, 0);

    // ---- port C plain modes (R4, R11)
    wr(3'd0, 8'h0C);
    wr(3'd3, 8'h2A);
    settle();
    chk("R4 mode 11 all outputs", portCOe, 6'h3F);
    chk("R4 mode 11 drives latch", portCOut, 6'h2A);
    rd(3'd3, 8'h2A, "R4 read port C outputs");
    wr(3'd0, 8'h30);
    portCIn = 6'h11;
    waitN(4);
    rd(3'd3, 8'h11, "R4 read port C inputs");
    portCIn = 6'h3F;
    waitN(4);
    rd(3'd0, 8'h24, "R11 strobe edges ignored in mode 00");

    // ---- strobed input on A (R5, R8, R9)
    wr(3'd0, 8'h14);
    settle();
    chk("R5 mode 01 pin enables", portCOe, 6'h3B);
    chk("R5 mode 01 pin values", portCOut, 6'h28);
    portAIn = 8'h77;
    @(negedge clk);
    portCIn[2] = 1'b0;
    waitN(2);
    settle();
    chk("R8 buffer full on third edge", portCOut[1], 1);
    waitN(1);
    portAIn = 8'h11;
    chk("R5 BF pin high", portCOut, 6'h2A);
    rd(3'd0, 8'h06, "R8 status BF set, no intr yet");
    @(negedge clk);
    portCIn[2] = 1'b1;
    waitN(4);
    rd(3'd0, 8'h07, "R8 status intr on rising strobe");
    settle();
    chk("R5 intr pin high", portCOut, 6'h2B);
    rd(3'd1, 8'h77, "R9 read returns captured data");
    rd(3'd0, 8'h04, "R9 read clears BF and intr");

    // ---- enable off (R8)
    wr(3'd0, 8'h04);
    portAIn = 8'h3E;
    @(negedge clk);
    portCIn[2] = 1'b0;
    waitN(4);
    portCIn[2] = 1'b1;
    waitN(4);
    rd(3'd0, 8'h02, "R8 no intr with enable clear");
    rd(3'd1, 8'h3E, "R9 captured data second strobe");
    rd(3'd0, 8'h00, "R9 flags cleared by read");

    // ---- strobed output on A (R10)
    wr(3'd0, 8'h15);
    rd(3'd0, 8'h04, "R10 status before write");
    wr(3'd1, 8'h9C);
    settle();
    chk("R10 port A drives write data", portAOut, 8'h9C);
    rd(3'd0, 8'h06, "R10 write sets BF");
    @(negedge clk);
    portCIn[2] = 1'b0;
    waitN(4);
    rd(3'd0, 8'h04, "R10 strobe fall clears BF");
    portCIn[2] = 1'b1;
    waitN(4);
    rd(3'd0, 8'h05, "R10 strobe rise sets intr");
    wr(3'd1, 8'h9D);
    rd(3'd0, 8'h06, "R10 write clears intr");

    // ---- both handshakes (R11, R6)
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R11 flags cleared outside strobed mode");
    wr(3'd0, 8'h38);
    settle();
    chk("R6 mode 10 pin enables", portCOe, 6'h1B);
    portBIn = 8'hE1;
    @(negedge clk);
    portCIn[5] = 1'b0;
    waitN(4);
    settle();
    chk("R6 B BF pin", portCOut, 6'h10);
    portBIn = 8'h00;
    rd(3'd0, 8'h34, "R6 status B BF");
    portCIn[5] = 1'b1;
    waitN(4);
    settle();
    chk("R6 B intr pin", portCOut, 6'h18);
    rd(3'd0, 8'h3C, "R6 status B intr");
    rd(3'd2, 8'hE1, "R9 port B captured data");
    rd(3'd0, 8'h24, "R9 port B flags cleared");

    // ---- unused selects (R12)
    wr(3'd4, 8'hFF);
    wr(3'd7, 8'hFF);
    rd(3'd0, 8'h24, "R12 write to select 4 ignored");
    rd(3'd4, 8'h00, "R12 select 4 reads zero");
    rd(3'd7, 8'h00, "R12 select 7 reads zero");
    settle();
    chk("R12 timerCmd unchanged", timerCmd, 0);

    // ---- reset mid-run (R1)
    wr(3'd0, 8'hCF);
    wr(3'd2, 8'h55);
    @(negedge clk);
    rst = 1'b1;
    waitN(2);
    rst = 1'b0;
    settle();
    chk("R1 port C released by reset", portCOe, 0);
    chk("R1 port B latch cleared", portBOut, 0);
    chk("R1 timerCmd cleared", timerCmd, 0);
    rd(3'd0, 8'h00, "R1 status cleared by reset");

    waitN(2);
    summary();
  end
endmodule